// File: doc/BRIEF.md
# Energy-to-Pulse Rate Converter

The block converts a stream of signed per-sample energy values into a train of fixed-width output pulses. Each pulse stands for a fixed quantum of energy. A hidden summation register adds up every valid sample. When the magnitude of the running sum reaches a threshold derived from a programmable pulse-rate value, three things happen: the sum is cleared, one pulse is requested and the sign of the sum is latched onto a direction pin.

Pulses start only at one of four quarter positions inside a repeating slot, chosen by a phase input. Outputs of several devices set to different phases can therefore be combined on one line without their pulses colliding.

Both pins can be forced from two user data inputs. Both pins can also run in open-drain mode, so they can share a wire-AND line with an external pull-up. Two flags are provided. An event flag tracks recent pulse activity. An overflow flag reports energy quanta that arrived faster than pulses could be issued.

Top module: `energy_pulse_gen`

## Requirements
- R1: On each valid sample, the sample is added to the summation register. If the magnitude of the new sum is greater than or equal to the threshold (rate_i shifted left by THR_SHIFT, default 0), a pulse is requested and the register is cleared to zero, discarding any remainder. Otherwise the sum is kept.
- R2: A rate_i value below 2 (2^-4 in the 5-fraction-bit format) is treated as 2.
- R3: dir_o is 1 when the sum that triggered the latest request was negative, and 0 when it was not. It changes one cycle after the triggering sample and holds until the next request. It is 0 after reset.
- R4: Each pulse holds pulse_o high for PW_CYC (default 4) consecutive cycles.
- R5: A pending request starts its pulse on the clock edge n (counted from 1 after reset release) for which (n-1) mod SLOT_CYC equals phase_i * SLOT_CYC/4. With the defaults, SLOT_CYC is 16 and the quarter step is 4 cycles.
- R6: When override_i is 1, the pulse pin level follows user_pulse_i and the direction pin level follows user_dir_i, combinationally.
- R7: When open_drain_i is 1, each pin drives a data value of 0. Its enable (pulse_oe_o, dir_oe_o) is 1 only while the pin level is 0. When open_drain_i is 0, the enables are 1 and the data values equal the levels.
- R8: If a request arrives while an earlier one has not yet started its pulse, ovf_o is high for exactly the one following cycle and the two requests merge into one pulse.
- R9: evt_o goes to 1 with each pulse start. It returns to 0 after EVT_WIN (default 64) cycles with no pulse start.
- R10: After reset, pulse_o, dir_o, evt_o and ovf_o are 0, and both enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Energy sample strobe |
| energy_i | input | EW | Signed energy sample |
| rate_i | input | RW | Unsigned pulse-rate value, 5 fraction bits |
| phase_i | input | 2 | Pulse start quarter within the slot |
| override_i | input | 1 | Pins follow user data bits |
| user_pulse_i | input | 1 | Pulse pin level under override |
| user_dir_i | input | 1 | Direction pin level under override |
| open_drain_i | input | 1 | Pull-down-only pin mode |
| pulse_o | output | 1 | Pulse pin data |
| pulse_oe_o | output | 1 | Pulse pin drive enable |
| dir_o | output | 1 | Direction pin data |
| dir_oe_o | output | 1 | Direction pin drive enable |
| evt_o | output | 1 | Recent pulse activity flag |
| ovf_o | output | 1 | Merged-request overflow flag |

## Verification
Each result has a fixed due time after its stimulus.

- A sample clocked on an edge updates the sum, the pending request and dir_o on that same edge.
- ovf_o is high for the cycle after that edge.
- The pulse appears only after the slot edge that matches the phase. It is therefore found by scanning at falling edges, and its edge number is then compared against a bench edge counter started at reset release.
- Override and open-drain effects are combinational, so they are checked half a cycle after the inputs change.
- The event flag is checked before and after an idle window longer than EVT_WIN.

// File: rtl/epg_pkg.sv
package epg_pkg;
  localparam int unsigned PHASE_W = 2;
  localparam int unsigned N_PINS  = 2;
  localparam int unsigned MIN_RATE = 2; // 2^-4 with 5 fraction bits
  typedef logic [PHASE_W-1:0] phase_t;
  typedef enum logic [0:0] {PIN_PULSE = 1'b0, PIN_DIR = 1'b1} pin_idx_e;
endpackage

// File: rtl/epg_accum.sv
module epg_accum #(
  parameter int unsigned EW = 24,
  parameter int unsigned RW = 24,
  parameter int unsigned THR_SHIFT = 0,
  localparam int unsigned AW = ((EW > RW + THR_SHIFT) ? EW : RW + THR_SHIFT) + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [EW-1:0] energy_i,
  input  logic        [RW-1:0] rate_i,
  output logic                 fire_o,
  output logic                 neg_o
);
  import epg_pkg::*;

  logic signed [AW-1:0] acc_q, sum;
  logic [AW-1:0] mag, thr;
  logic [RW-1:0] rate_c;

  always_comb begin
    rate_c = (rate_i < RW'(MIN_RATE)) ? RW'(MIN_RATE) : rate_i;
    thr    = AW'(rate_c) << THR_SHIFT;
    sum    = acc_q + {{(AW-EW){energy_i[EW-1]}}, energy_i};
    mag    = sum[AW-1] ? AW'(-sum) : AW'(sum);
    fire_o = valid_i && (mag >= thr);
    neg_o  = sum[AW-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (fire_o)  acc_q <= '0;
    else if (valid_i) acc_q <= sum;
  end

  assert_clear_after_fire_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (acc_q == '0));
endmodule

// File: rtl/epg_sched.sv
module epg_sched #(
  parameter int unsigned SLOT_CYC = 16,
  parameter int unsigned PW_CYC   = 4,
  parameter int unsigned EVT_WIN  = 64,
  localparam int unsigned SW  = $clog2(SLOT_CYC),
  localparam int unsigned QTR = SLOT_CYC / 4,
  localparam int unsigned PCW = $clog2(PW_CYC + 1),
  localparam int unsigned WCW = $clog2(EVT_WIN + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  logic            neg_i,
  input  epg_pkg::phase_t phase_i,
  output logic            pulse_o,
  output logic            dir_o,
  output logic            evt_o,
  output logic            ovf_o
);
  logic [SW-1:0]  slot_cnt, off;
  logic [PCW-1:0] pw_cnt;
  logic [WCW-1:0] win_cnt;
  logic pend_q, start;

  always_comb begin
    off   = SW'(phase_i) * SW'(QTR);
    start = pend_q && (slot_cnt == off);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_cnt <= '0;
      pend_q   <= 1'b0;
      ovf_o    <= 1'b0;
      dir_o    <= 1'b0;
    end else begin
      slot_cnt <= (slot_cnt == SW'(SLOT_CYC - 1)) ? '0 : slot_cnt + 1'b1;
      pend_q   <= fire_i | (pend_q & ~start);
      ovf_o    <= fire_i & pend_q & ~start;
      if (fire_i) dir_o <= neg_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_o <= 1'b0;
      pw_cnt  <= '0;
    end else if (start) begin
      pulse_o <= 1'b1;
      pw_cnt  <= PCW'(PW_CYC - 1);
    end else if (pulse_o) begin
      if (pw_cnt == '0) pulse_o <= 1'b0;
      else              pw_cnt  <= pw_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_o   <= 1'b0;
      win_cnt <= '0;
    end else if (start) begin
      evt_o   <= 1'b1;
      win_cnt <= '0;
    end else if (evt_o) begin
      if (win_cnt == WCW'(EVT_WIN - 1)) evt_o <= 1'b0;
      else                              win_cnt <= win_cnt + 1'b1;
    end
  end

  initial assert_slot_fits_R4: assert (PW_CYC <= SLOT_CYC && PW_CYC > 0 && SLOT_CYC % 4 == 0);

  assert_phase_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> ($past(slot_cnt) == $past(off)));
  assert_ovf_needs_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $past(pend_q));
  assert_evt_on_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o) |-> $rose(pulse_o));
endmodule

// File: rtl/epg_pad.sv
module epg_pad (
  input  logic lvl_i,
  input  logic open_drain_i,
  output logic pin_o,
  output logic oe_o
);
  always_comb begin
    pin_o = open_drain_i ? 1'b0 : lvl_i;
    oe_o  = open_drain_i ? ~lvl_i : 1'b1;
  end
endmodule

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen #(
  parameter int unsigned EW        = 24,
  parameter int unsigned RW        = 24,
  parameter int unsigned THR_SHIFT = 0,
  parameter int unsigned SLOT_CYC  = 16,
  parameter int unsigned PW_CYC    = 4,
  parameter int unsigned EVT_WIN   = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [EW-1:0] energy_i,
  input  logic        [RW-1:0] rate_i,
  input  logic [1:0]           phase_i,
  input  logic                 override_i,
  input  logic                 user_pulse_i,
  input  logic                 user_dir_i,
  input  logic                 open_drain_i,
  output logic                 pulse_o,
  output logic                 pulse_oe_o,
  output logic                 dir_o,
  output logic                 dir_oe_o,
  output logic                 evt_o,
  output logic                 ovf_o
);
  import epg_pkg::*;

  logic fire, neg, pulse_int, dir_int;
  logic [N_PINS-1:0] lvl, pin, oe;

  epg_accum #(.EW(EW), .RW(RW), .THR_SHIFT(THR_SHIFT)) u_accum (
    .clk_i, .rst_ni, .valid_i, .energy_i, .rate_i,
    .fire_o(fire), .neg_o(neg)
  );

  epg_sched #(.SLOT_CYC(SLOT_CYC), .PW_CYC(PW_CYC), .EVT_WIN(EVT_WIN)) u_sched (
    .clk_i, .rst_ni, .fire_i(fire), .neg_i(neg), .phase_i(phase_t'(phase_i)),
    .pulse_o(pulse_int), .dir_o(dir_int), .evt_o, .ovf_o
  );

  always_comb begin
    lvl[PIN_PULSE] = override_i ? user_pulse_i : pulse_int;
    lvl[PIN_DIR]   = override_i ? user_dir_i   : dir_int;
  end

  for (genvar g = 0; g < N_PINS; g++) begin : g_pad
    epg_pad u_pad (.lvl_i(lvl[g]), .open_drain_i, .pin_o(pin[g]), .oe_o(oe[g]));
  end

  assign pulse_o    = pin[PIN_PULSE];
  assign pulse_oe_o = oe[PIN_PULSE];
  assign dir_o      = pin[PIN_DIR];
  assign dir_oe_o   = oe[PIN_DIR];

  assert_od_never_drives_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_drain_i && oe[PIN_PULSE]) |-> !pin[PIN_PULSE]);
endmodule

// File: tb/energy_pulse_gen_bench.sv
`timescale 1ns/1ps
module energy_pulse_gen_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0;
  logic signed [23:0] energy = '0;
  logic [23:0] rate = 24'd100;
  logic [1:0] phase = 2'd0;
  logic ovr = 1'b0, upulse = 1'b0, udir = 1'b0, od = 1'b0;
  logic pulse, pulse_oe, dir, dir_oe, evt, ovf;
  int n_run = 0, n_fail = 0, ecnt = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  energy_pulse_gen u_energy_pulse_gen (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .energy_i(energy), .rate_i(rate),
    .phase_i(phase), .override_i(ovr), .user_pulse_i(upulse), .user_dir_i(udir),
    .open_drain_i(od), .pulse_o(pulse), .pulse_oe_o(pulse_oe), .dir_o(dir),
    .dir_oe_o(dir_oe), .evt_o(evt), .ovf_o(ovf)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int e);
    @(negedge clk); valid = 1'b1; energy = 24'(e);
    @(negedge clk); valid = 1'b0;
  endtask

  // scans falling edges for a pulse; returns edge number or -1
  task automatic find_rise(input int lim, output int n);
    n = -1;
    for (int i = 0; i < lim; i++) begin
      if (pulse) begin n = ecnt; break; end
      @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 pulse", pulse, 0); chk("R10 dir", dir, 0);
    chk("R10 evt", evt, 0);     chk("R10 ovf", ovf, 0);
    chk("R10 oe", pulse_oe & dir_oe, 1);
  endtask

  task automatic t_positive();
    int n, w;
    rate = 24'd100;
    send(30); send(30); send(30);
    find_rise(40, n);
    chk("R1 no pulse below threshold", n, -1);
    send(30);
    chk("R3 dir positive", dir, 0);
    find_rise(40, n);
    chk("R1 pulse at threshold", (n > 0) ? 1 : 0, 1);
    chk("R5 phase0 slot", (n - 1) % 16, 0);
    w = 0;
    while (pulse) begin w++; @(negedge clk); end
    chk("R4 width", w, 4);
    chk("R9 evt set", evt, 1);
    settle();
    send(30); send(30); send(30);
    find_rise(40, n);
    chk("R1 sum cleared on fire", n, -1);
    send(10);
    find_rise(40, n);
    chk("R1 exact threshold fires", (n > 0) ? 1 : 0, 1);
    settle();
  endtask

  task automatic t_negative();
    int n;
    send(-60); send(-39);
    find_rise(40, n);
    chk("R1 negative below", n, -1);
    send(-1);
    chk("R3 dir negative", dir, 1);
    find_rise(40, n);
    chk("R1 negative magnitude fires", (n > 0) ? 1 : 0, 1);
    settle();
    chk("R3 dir held", dir, 1);
  endtask

  task automatic t_phase(input int ph);
    int n;
    phase = 2'(ph);
    send(200);
    find_rise(40, n);
    chk("R5 phase slot", (n - 1) % 16, 4 * ph);
    settle();
  endtask

  task automatic t_rate_clamp();
    int n;
    rate = 24'd0;
    send(1);
    find_rise(40, n);
    chk("R2 clamp no fire at 1", n, -1);
    send(1);
    find_rise(40, n);
    chk("R2 clamp fires at 2", (n > 0) ? 1 : 0, 1);
    settle();
    rate = 24'd100;
  endtask

  task automatic t_overflow();
    int seen = 0;
    rate = 24'd2;
    @(negedge clk); valid = 1'b1; energy = 24'sd5;
    @(negedge clk); seen |= ovf;
    @(negedge clk); seen |= ovf;
    @(negedge clk); valid = 1'b0; seen |= ovf;
    @(negedge clk); seen |= ovf;
    chk("R8 overflow flagged", seen, 1);
    chk("R8 overflow one cycle", ovf, 0);
    settle();
    rate = 24'd100;
  endtask

  task automatic t_evt_clear();
    repeat (80) @(negedge clk);
    chk("R9 evt cleared", evt, 0);
  endtask

  task automatic t_override();
    @(negedge clk); ovr = 1'b1; upulse = 1'b1; udir = 1'b0;
    #1 chk("R6 pulse follows user", pulse, 1); chk("R6 dir follows user", dir, 0);
    upulse = 1'b0; udir = 1'b1;
    #1 chk("R6 pulse low", pulse, 0); chk("R6 dir high", dir, 1);
  endtask

  task automatic t_open_drain();
    od = 1'b1; upulse = 1'b1; udir = 1'b0;
    #1 chk("R7 high level data", pulse, 0); chk("R7 high level released", pulse_oe, 0);
    chk("R7 low level driven", dir_oe, 1); chk("R7 low level data", dir, 0);
    upulse = 1'b0; udir = 1'b1;
    #1 chk("R7 pulse pin pulls", pulse_oe, 1); chk("R7 dir released", dir_oe, 0);
    od = 1'b0; ovr = 1'b0;
    #1 chk("R7 push-pull enables", pulse_oe & dir_oe, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_positive();
    t_negative();
    t_phase(1); t_phase(2); t_phase(3);
    phase = 2'd0;
    t_rate_clamp();
    t_overflow();
    t_evt_clear();
    t_override();
    t_open_drain();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule